// File: doc/BRIEF.md
# Matched-Pair Run Detector

This block watches two single-bit signals that arrive together on each clock cycle. It raises a flag whenever the two signals have held equal values for a number of back-to-back cycles, and the present cycle counts toward that number. The run length is a parameter, `RUN_LEN`, and defaults to four. Both "both low" and "both high" count as agreement, and the value of the pair may change from one cycle to the next without breaking the run.

The history of earlier cycles lives in a small saturating counter that is updated on the rising clock edge. The present cycle's comparison feeds the flag through combinational logic, so the flag is a Mealy output. It goes high in the same cycle that completes the run and falls in the same cycle as the first disagreement. The counter value is also exported so that surrounding logic or a debug view can see how far into a run the block is.

Top module: `match_run_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the run count becomes 0. After reset is released, `hit` cannot assert until `RUN_LEN` agreeing cycles have been seen.
- R2: At each rising edge where `in_a == in_b` and `run_cnt` is below `RUN_LEN-1`, `run_cnt` increases by exactly one.
- R3: `run_cnt` saturates at `RUN_LEN-1` (3 by default). Further agreeing cycles leave it at that value.
- R4: At any rising edge where `in_a != in_b`, `run_cnt` becomes 0.
- R5: `hit` is 1 exactly when `in_a == in_b` in the present cycle and `run_cnt == RUN_LEN-1`, that is, when the present cycle and each of the preceding `RUN_LEN-1` cycles agree. Otherwise `hit` is 0.
- R6: `hit` rises during the `RUN_LEN`-th agreeing cycle itself, with no extra register delay.
- R7: While agreement continues beyond `RUN_LEN` cycles, `hit` stays 1 in every such cycle.
- R8: A disagreement drives `hit` to 0 in that same cycle. A fresh run of `RUN_LEN` agreements is then needed before `hit` returns to 1.
- R9: Agreement counts whether both inputs are 0 or both are 1. A run may mix the two.
- R10: For the input pair sequences a=0,1,1,0,1,1,1,0,0,0,1,1,0 and b=1,1,1,0,1,0,1,0,0,0,1,1,1 applied from reset, `hit` is 0,0,0,0,1,0,0,0,0,1,1,1,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | First compared bit |
| in_b | input | 1 | Second compared bit |
| hit | output | 1 | Combinational flag: run of agreement has reached `RUN_LEN` cycles |
| run_cnt | output | CNT_W | Registered count of earlier consecutive agreeing cycles, saturating at `RUN_LEN-1` |

## Verification
On every cycle, the assertions check the counter's step, clear and saturation rules against the comparator's result. They also check that `hit` never coexists with a disagreement and is never high right after a disagreement. Only the bench's scenarios can show the exact cycle in which `hit` first rises, that it rises in the agreeing cycle itself rather than one cycle later, and that mixed all-zero and all-one runs qualify. The bench scenarios also cover a reset arriving in the middle of a saturated run and the full reference sequence.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  // Counter width able to hold the saturation value run_len-1.
  function automatic int run_cnt_w(input int run_len);
    if (run_len <= 2) return 1;
    return $clog2(run_len);
  endfunction

endpackage

// File: rtl/mrd_compare.sv
module mrd_compare (
  input  logic in_a,
  input  logic in_b,
  output logic eq
);

  // Agreement: both low or both high.
  assign eq = ~(in_a ^ in_b);

endmodule

// File: rtl/mrd_run_counter.sv
module mrd_run_counter #(
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = mrd_pkg::run_cnt_w(RUN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eq,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (!eq)             cnt_nxt = '0;
    else if (cnt == SAT) cnt_nxt = SAT;
    else                 cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  // R1: reset empties the history
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> cnt == '0);

  // R2: one step per agreeing cycle below saturation
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (eq && cnt != SAT) |=> cnt == $past(cnt) + 1'b1);

  // R3: saturation holds
  assert_saturate_R3: assert property (@(posedge clk) disable iff (rst)
    (eq && cnt == SAT) |=> cnt == SAT);

  // R4: disagreement empties the history
  assert_mismatch_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !eq |=> cnt == '0);

endmodule

// File: rtl/mrd_hit_logic.sv
module mrd_hit_logic #(
  parameter int RUN_LEN = 4,
  parameter int CNT_W   = mrd_pkg::run_cnt_w(RUN_LEN)
) (
  input  logic             eq,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(RUN_LEN - 1);

  // Mealy output: present comparison gated by full history.
  assign hit = eq && (cnt == SAT);

endmodule

// File: rtl/match_run_detector.sv
module match_run_detector #(
  parameter int RUN_LEN = 4,
  localparam int CNT_W  = mrd_pkg::run_cnt_w(RUN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_a,
  input  logic             in_b,
  output logic             hit,
  output logic [CNT_W-1:0] run_cnt
);

  logic eq;

  mrd_compare u_cmp (
    .in_a (in_a),
    .in_b (in_b),
    .eq   (eq)
  );

  mrd_run_counter #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .eq  (eq),
    .cnt (run_cnt)
  );

  mrd_hit_logic #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_hit (
    .eq  (eq),
    .cnt (run_cnt),
    .hit (hit)
  );

  // R8: a disagreement at the ports never coexists with the flag
  assert_mismatch_drops_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (in_a != in_b) |-> !hit);

  // R5: a flag needs the previous cycle to have agreed as well
  assert_hit_history_R5: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(in_a == in_b));

  // R8: no flag in the cycle right after a disagreement
  assert_no_hit_after_break_R8: assert property (@(posedge clk) disable iff (rst)
    $past(in_a != in_b) |-> !hit);

endmodule

// File: tb/match_run_detector_bench.sv
`timescale 1ns/1ps
module match_run_detector_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_a = 1'b0;
  logic       in_b = 1'b1;
  logic       hit;
  logic [1:0] run_cnt;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  match_run_detector u_match_run_detector (
    .clk     (clk),
    .rst     (rst),
    .in_a    (in_a),
    .in_b    (in_b),
    .hit     (hit),
    .run_cnt (run_cnt)
  );

  // Entry bits: {a, b, expected hit, expected count[1:0]}
  localparam logic [4:0] VEC [0:12] = '{
    5'b01000, 5'b11000, 5'b11001, 5'b00010, 5'b11111,
    5'b10011, 5'b11000, 5'b00001, 5'b00010, 5'b00111,
    5'b11111, 5'b11111, 5'b01011
  };

  // Drive after a falling edge, then sample before the next rising edge.
  task automatic step(input logic a, input logic b, input logic r);
    @(negedge clk);
    in_a = a;
    in_b = b;
    rst  = r;
    #2;
  endtask

  task automatic check(input string req, input logic exp_hit, input logic [1:0] exp_cnt);
    checks++;
    if (hit !== exp_hit || run_cnt !== exp_cnt) begin
      failures++;
      $display("FAIL %s: hit=%b cnt=%0d expected hit=%b cnt=%0d",
               req, hit, run_cnt, exp_hit, exp_cnt);
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: hit=%b cnt=%0d expected run to finish", hit, run_cnt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset with agreeing inputs keeps the flag low
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    check("R1 reset", 1'b0, 2'd0);

    // R10 reference sequence, also R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 13; i++) begin
      step(VEC[i][4], VEC[i][3], 1'b0);
      check($sformatf("R10 vec%0d", i), VEC[i][2], VEC[i][1:0]);
    end

    // R9: alternating 00/11 pairs still form a run
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0); check("R9 first", 1'b0, 2'd0);
    step(1'b1, 1'b1, 1'b0); check("R2 step1", 1'b0, 2'd1);
    step(1'b0, 1'b0, 1'b0); check("R2 step2", 1'b0, 2'd2);
    step(1'b1, 1'b1, 1'b0); check("R6 fourth match", 1'b1, 2'd3);

    // R3 / R7: long run saturates and the flag holds
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b0, 1'b0);
      check("R7 hold", 1'b1, 2'd3);
    end

    // R8: break drops the flag at once; three matches are not enough
    step(1'b0, 1'b1, 1'b0); check("R8 break", 1'b0, 2'd3);
    step(1'b1, 1'b1, 1'b0); check("R4 cleared", 1'b0, 2'd0);
    step(1'b1, 1'b1, 1'b0); check("R8 rerun2", 1'b0, 2'd1);
    step(1'b1, 1'b1, 1'b0); check("R8 rerun3", 1'b0, 2'd2);
    step(1'b1, 1'b1, 1'b0); check("R8 rerun4", 1'b1, 2'd3);
    step(1'b1, 1'b1, 1'b0); check("R3 saturated", 1'b1, 2'd3);

    // R1: reset during a saturated run, then a full run again
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0); check("R1 mid-run reset", 1'b0, 2'd0);
    step(1'b0, 1'b0, 1'b0); check("R1 after2", 1'b0, 2'd1);
    step(1'b1, 1'b1, 1'b0); check("R1 after3", 1'b0, 2'd2);
    step(1'b0, 1'b0, 1'b0); check("R1 after4", 1'b1, 2'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule